// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block picks which of six interrupt sources a small 8-bit CPU services next. Each source has its own enable bit, and one global enable gates all of them. Each source also has a two-bit priority level. The level is built from one bit in a "level-high" register and one bit in a "level-low" register. Among the sources that are enabled and requesting, the arbiter presents one vector index, its level and a request line to the CPU.

The block keeps an in-service mask with one bit per level. An acknowledge from the CPU marks the granted level as active. A return strobe retires the most recent (highest) active level. A new request reaches the CPU only when its level is strictly above every level in service. Software loads the three registers through a byte-wide write port. Clearing the source flags, the vector address table and the CPU pipeline are handled elsewhere.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the enable register and both level registers are zero, the in-service mask is zero and `irq_req` is low.
- R2: A write with `wr_sel` = 0 loads the enable register, 1 loads the level-low register and 2 loads the level-high register. Bit i of the written byte belongs to source i. A write with `wr_sel` = 3 changes nothing.
- R3: Source i is considered only while `src_req[i]`, enable bit i and enable bit 7 (global) are all 1. The source indices are: 0 external line 0, 1 timer 0, 2 external line 1, 3 timer 1, 4 serial port, 5 timer 2. While bit 7 is 0, `irq_req` stays low.
- R4: The level of source i is {level-high bit i, level-low bit i}, from 0 to 3. Among the eligible sources, the one with the highest level is presented.
- R5: When several eligible sources share the highest level, the lowest source index wins, and `irq_vec` carries that index.
- R6: An `ack` while `irq_req` is high sets the in-service bit at `irq_lvl` on the next clock. An `ack` while `irq_req` is low has no effect.
- R7: While the in-service mask is nonzero, only a source whose level is strictly above the highest in-service level can raise `irq_req`. While level 3 is in service, nothing can raise it.
- R8: `reti` clears the highest set in-service bit. With an empty mask it has no effect. When `reti` and a valid `ack` arrive in the same cycle, the clear is applied first and then the acknowledged level is set.
- R9: `irq_lvl` gives the presented source's level. While `irq_req` is low, `irq_vec` and `irq_lvl` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 enable, 1 level-low, 2 level-high, 3 none |
| wr_data | input | 8 | Write data byte |
| src_req | input | 6 | Pending flags of the six sources |
| ack | input | 1 | CPU accepts the presented vector |
| reti | input | 1 | CPU returns from the current handler |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | 3 | Index of the presented source |
| irq_lvl | output | 2 | Level of the presented source |
| active_mask | output | 4 | In-service mask, one bit per level |

## Verification
The bench builds the block with its default values: six sources, four levels and an 8-bit write port. With these values the whole arbitration space can be reached. That includes the tie between sources at one level, the blocking at level 3, and a nest three levels deep. The bench drives nests of levels 0, 1 and 3, a same-cycle return and acknowledge, and toggling of the global enable. A behavioural model is compared with the outputs on every cycle.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    parameter int unsigned NSRC    = 6;
    parameter int unsigned LVL_W   = 2;
    parameter int unsigned LVLS    = 1 << LVL_W;
    parameter int unsigned VEC_W   = $clog2(NSRC);
    parameter int unsigned DW      = 8;
    parameter int unsigned GEN_BIT = DW - 1;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [LVLS-1:0]  lmask_t;

    typedef enum logic [1:0] {
        SEL_ENABLE  = 2'd0,
        SEL_PRIO_LO = 2'd1,
        SEL_PRIO_HI = 2'd2,
        SEL_NONE    = 2'd3
    } wsel_e;

    typedef struct packed {
        logic valid;
        lvl_t lvl;
        vec_t vec;
    } grant_t;

    // Index of the highest set bit of a level mask (0 when empty).
    function automatic lvl_t top_level(input lmask_t m);
        lvl_t r;
        r = '0;
        for (int i = 0; i < int'(LVLS); i++) begin
            if (m[i]) r = lvl_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_regs.sv
module irq_regs
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned N_SRC  = NSRC,
    parameter int unsigned DATA_W = DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [N_SRC-1:0]  en_q,
    output logic              glb_q,
    output logic [N_SRC-1:0]  plo_q,
    output logic [N_SRC-1:0]  phi_q
);
    localparam int unsigned GBIT = DATA_W - 1;

    wsel_e sel;
    assign sel = wsel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            glb_q <= 1'b0;
            plo_q <= '0;
            phi_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_ENABLE: begin
                    en_q  <= wr_data[N_SRC-1:0];
                    glb_q <= wr_data[GBIT];
                end
                SEL_PRIO_LO: plo_q <= wr_data[N_SRC-1:0];
                SEL_PRIO_HI: phi_q <= wr_data[N_SRC-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned N_SRC = NSRC
) (
    input  logic [N_SRC-1:0] src_req,
    input  logic [N_SRC-1:0] en,
    input  logic             glb,
    input  logic [N_SRC-1:0] plo,
    input  logic [N_SRC-1:0] phi,
    input  lmask_t           in_service,
    output grant_t           grant
);
    logic [N_SRC-1:0] qual;
    lvl_t             src_lvl [N_SRC];

    for (genvar s = 0; s < int'(N_SRC); s++) begin : g_src
        assign qual[s]    = src_req[s] & en[s] & glb;
        assign src_lvl[s] = {phi[s], plo[s]};
    end

    lvl_t cur;
    logic busy;
    assign cur  = top_level(in_service);
    assign busy = |in_service;

    always_comb begin
        grant = '0;
        for (int l = int'(LVLS) - 1; l >= 0; l--) begin
            for (int s = 0; s < int'(N_SRC); s++) begin
                if (!grant.valid && qual[s] && int'(src_lvl[s]) == l
                    && (!busy || l > int'(cur))) begin
                    grant.valid = 1'b1;
                    grant.lvl   = lvl_t'(l);
                    grant.vec   = vec_t'(s);
                end
            end
        end
    end

endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
    import irq_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ack,
    input  logic   reti,
    input  grant_t grant,
    output lmask_t mask_q
);
    lmask_t nxt;

    always_comb begin
        nxt = mask_q;
        if (reti && (|mask_q)) nxt[top_level(mask_q)] = 1'b0;
        if (ack && grant.valid) nxt[grant.lvl] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= nxt;
    end

endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned N_SRC  = NSRC,
    parameter int unsigned DATA_W = DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [N_SRC-1:0]  src_req,
    input  logic              ack,
    input  logic              reti,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    output logic [LVL_W-1:0]  irq_lvl,
    output logic [LVLS-1:0]   active_mask
);
    logic [N_SRC-1:0] en_q, plo_q, phi_q;
    logic             glb_q;
    grant_t           grant;
    lmask_t           mask_q;

    irq_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .en_q(en_q), .glb_q(glb_q), .plo_q(plo_q), .phi_q(phi_q)
    );

    irq_arbiter #(.N_SRC(N_SRC)) u_arb (
        .src_req(src_req), .en(en_q), .glb(glb_q), .plo(plo_q), .phi(phi_q),
        .in_service(mask_q), .grant(grant)
    );

    irq_inservice u_isr (
        .clk(clk), .rst(rst), .ack(ack), .reti(reti), .grant(grant), .mask_q(mask_q)
    );

    assign irq_req     = grant.valid;
    assign irq_vec     = grant.vec;
    assign irq_lvl     = grant.lvl;
    assign active_mask = mask_q;

endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker
    import irq_ctrl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NSRC-1:0]  src_req,
    input logic             ack,
    input logic             reti,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input logic [LVL_W-1:0] irq_lvl,
    input logic [LVLS-1:0]  active_mask,
    input logic             glb
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (active_mask == '0));

    assert_global_gate_R3: assert property (@(posedge clk) disable iff (rst)
        !glb |-> !irq_req);

    assert_vec_pending_R3: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ((src_req >> irq_vec) & NSRC'(1)) != '0);

    assert_ack_marks_R6: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_req) |=> active_mask[$past(irq_lvl)]);

    assert_strict_nest_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_req && (|active_mask)) |-> (irq_lvl > top_level(active_mask)));

    assert_reti_pops_R8: assert property (@(posedge clk) disable iff (rst)
        (reti && !ack && (|active_mask)) |=>
            ($countones(active_mask) == $countones($past(active_mask)) - 1));

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !irq_req |-> (irq_vec == '0 && irq_lvl == '0));

endmodule

bind nested_irq_ctrl irq_ctrl_checker u_chk (
    .clk(clk), .rst(rst), .src_req(src_req), .ack(ack), .reti(reti),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
    .active_mask(active_mask), .glb(glb_q)
);

// File: tb/nested_irq_ctrl_bench.sv
module nested_irq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [5:0] src_req = 6'd0;
    logic       ack = 1'b0;
    logic       reti = 1'b0;
    logic       irq_req;
    logic [2:0] irq_vec;
    logic [1:0] irq_lvl;
    logic [3:0] active_mask;

    always #5 clk = ~clk;

    nested_irq_ctrl u_nested_irq_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .src_req(src_req), .ack(ack), .reti(reti), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_lvl(irq_lvl), .active_mask(active_mask)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    bit [7:0] m_en;
    bit [5:0] m_lo, m_hi;
    bit [3:0] m_mask;

    task automatic model_out(output bit r, output int v, output int l);
        int cur;
        r = 0; v = 0; l = 0; cur = -1;
        for (int i = 0; i < 4; i++) if (m_mask[i]) cur = i;
        if (m_en[7]) begin
            for (int lv = 3; lv >= 0; lv--) begin
                for (int s = 0; s < 6; s++) begin
                    if (!r && lv > cur && src_req[s] && m_en[s]
                        && (int'(m_hi[s]) * 2 + int'(m_lo[s])) == lv) begin
                        r = 1; v = s; l = lv;
                    end
                end
            end
        end
    endtask

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // compare outputs mid-cycle, then advance model across the edge
    task automatic step(string tag);
        bit r; int v; int l;
        bit [3:0] nm;
        #1;
        model_out(r, v, l);
        check(tag, "irq_req", int'(irq_req), int'(r));
        check(tag, "irq_vec", int'(irq_vec), v);
        check(tag, "irq_lvl", int'(irq_lvl), l);
        check(tag, "active_mask", int'(active_mask), int'(m_mask));
        @(posedge clk);
        if (rst) begin
            m_en = 0; m_lo = 0; m_hi = 0; m_mask = 0;
        end else begin
            nm = m_mask;
            if (reti && nm != 0) begin
                for (int i = 3; i >= 0; i--) begin
                    if (nm[i]) begin nm[i] = 0; break; end
                end
            end
            if (ack && r) nm[l] = 1;
            m_mask = nm;
            if (wr_en) begin
                case (wr_sel)
                    2'd0: m_en = wr_data;
                    2'd1: m_lo = wr_data[5:0];
                    2'd2: m_hi = wr_data[5:0];
                    default: ;
                endcase
            end
        end
        @(negedge clk);
    endtask

    task automatic wr(input bit [1:0] sel, input bit [7:0] d, string tag);
        wr_en = 1; wr_sel = sel; wr_data = d;
        step(tag);
        wr_en = 0;
    endtask

    task automatic do_ack(string tag);
        ack = 1; step(tag); ack = 0;
    endtask

    task automatic do_reti(string tag);
        reti = 1; step(tag); reti = 0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        m_en = 0; m_lo = 0; m_hi = 0; m_mask = 0;
        step("R1");
        rst = 0;
        // R1: idle after reset even with every source pending
        src_req = 6'h3F;
        step("R1");
        // R3: per-source enables without global bit
        wr(2'd0, 8'h3F, "R3");
        step("R3");
        // R2: select 3 writes nothing
        wr(2'd3, 8'hFF, "R2");
        step("R2");
        // R2/R3: global on
        wr(2'd0, 8'hBF, "R2");
        step("R5");
        // R5/R3: tie at level 0, bit positions of serial and timer 2
        src_req = 6'b110000; step("R5");
        src_req = 6'b100000; step("R3");
        src_req = 6'b001010; step("R5");
        // R3: disabled source is skipped
        wr(2'd0, 8'hBE, "R3");
        src_req = 6'b000001; step("R3");
        wr(2'd0, 8'hBF, "R2");
        // R4: ext1 at level 3, timer1 at level 1
        wr(2'd1, 8'h0C, "R2");
        wr(2'd2, 8'h04, "R2");
        src_req = 6'h3F; step("R4");
        src_req = 6'b111011; step("R4");
        src_req = 6'b110001; step("R9");
        // R6/R7: service level 3, everything blocked
        src_req = 6'h3F;
        do_ack("R6");
        step("R7");
        // R8: return, then return with empty mask
        do_reti("R8");
        src_req = 6'd0;
        do_reti("R8");
        // R6: ack with no request ignored
        do_ack("R6");
        step("R6");
        // R7: nest 0 -> 1 -> 3
        src_req = 6'b000010;
        do_ack("R6");
        src_req = 6'b000011; step("R7");
        src_req = 6'b001000; step("R7");
        do_ack("R6");
        src_req = 6'b000001; step("R7");
        src_req = 6'b000100; step("R7");
        do_ack("R6");
        step("R7");
        do_reti("R8");
        // R8: reti + ack together
        ack = 1; reti = 1; step("R8"); ack = 0; reti = 0;
        step("R8");
        do_reti("R8");
        do_reti("R8");
        step("R8");
        // R3: global off blocks pending sources
        src_req = 6'h3F;
        wr(2'd0, 8'h3F, "R3");
        step("R3");
        // R1: reset clears everything
        rst = 1; step("R1"); rst = 0;
        step("R1");
        done = 1;
        summary();
        $finish;
    end

endmodule